// File: doc/BRIEF.md
# Converter Mode-Register Port

This block is the configuration front end of a data converter. It owns a small file of 8-bit mode registers and the four control pins through which a host sets them. A static strap input decides how those pins are read. With the strap low, the pins form a chip-select-framed serial slave: the host shifts in 16-bit frames that either write one register or read one back. Readback uses an output that can only pull the line low or let it go. With the strap high, no frames are decoded, and the same pins act as level inputs that directly choose the lane count, power-down and output drive strength.

All pins are oversampled by the fast system clock. Each pin passes through a two-flop synchronizer, and clock edges are found by comparing successive synchronized samples. No logic runs on the serial clock itself. The mode outputs always reflect whichever source the strap selects: the register fields in serial mode, or the pins in parallel mode.

Top module: `cnv_mode_port`

## Requirements
- R1: With `strap_i` low the block decodes serial frames; with `strap_i` high it decodes no frames, and the mode outputs follow the pins.
- R2: A frame is 16 bits, sampled on rising serial-clock edges while `csn_i` is low. The bits are, in order: the read flag, address bits 6 to 0, then data bits 7 to 0. A write (flag 0) stores the data byte in register A when `csn_i` rises. Register k appears on `cfg_regs_o[8k+7:8k]`.
- R3: In a read (flag 1), the second byte of the frame returns the addressed register on SDO, bit 7 first. Each bit is updated after the falling serial-clock edge that ends the bit before it, so the host can sample on rising edges 9 to 16.
- R4: `sdo_pull_o` is high only while a read returns a 0 bit. At every other time the line is released: during the first byte, outside a frame, and whenever the bit being returned is 1.
- R5: A read frame leaves every register unchanged.
- R6: A frame whose length is not exactly 16 rising edges when `csn_i` rises is discarded.
- R7: Registers exist at addresses 0 to 4. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R8: In parallel mode, `lane_code_o` is decoded from {`csn_i`,`sck_i`}: 00 gives 0 (one lane), 01 gives 1 (two lanes), and 10 or 11 give 2 (four lanes).
- R9: In parallel mode, `power_down_o` follows `sdi_i` and `low_drive_o` follows `sdo_pin_i` (1 selects the lower output current). Serial activity in this mode changes no register and never pulls SDO.
- R10: In serial mode, `power_down_o` is register 0 bit 0 and `low_drive_o` is register 1 bit 2. `lane_code_o` comes from register 1 bits 1:0: 0 gives 0, 1 gives 1, and 2 or 3 give 2.
- R11: Reset clears all registers and releases SDO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Mode strap: 0 serial, 1 parallel |
| csn_i | input | 1 | Chip select (serial) or lane select high bit (parallel) |
| sck_i | input | 1 | Serial clock (serial) or lane select low bit (parallel) |
| sdi_i | input | 1 | Serial data in (serial) or power-down request (parallel) |
| sdo_pin_i | input | 1 | SDO pin level, read as the drive-strength select in parallel mode |
| sdo_pull_o | output | 1 | Open-drain pull-down enable for SDO |
| cfg_regs_o | output | 40 | Register file, register k in bits 8k+7:8k |
| lane_code_o | output | 2 | Lane count code: 0, 1 or 2 for 1, 2 or 4 lanes |
| power_down_o | output | 1 | Power-down request |
| low_drive_o | output | 1 | Low output-current select |

## Verification
Every pin reaches the logic two system clocks after it changes. A detected serial-clock or chip-select edge acts one clock after that. So a register write lands three clocks after `csn_i` rises, and parallel-mode outputs follow their pins two clocks after the pins move. An SDO bit becomes valid three clocks after the falling serial-clock edge. The bench holds each serial-clock phase for six system clocks, samples SDO at the end of the low phase, and waits ten clocks after a frame (or four after a parallel pin change) before reading any output.

// File: rtl/cnv_mode_port.sv
module cnv_mode_port #(
  parameter int NREG = 5,
  parameter int DW   = 8,
  parameter int AW   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_i,
  input  logic                 csn_i,
  input  logic                 sck_i,
  input  logic                 sdi_i,
  input  logic                 sdo_pin_i,
  output logic                 sdo_pull_o,
  output logic [NREG*DW-1:0]   cfg_regs_o,
  output logic [1:0]           lane_code_o,
  output logic                 power_down_o,
  output logic                 low_drive_o
);
  localparam int FB = 1 + AW + DW;
  localparam int CW = $clog2(FB + 2);

  logic [2:0] csn_q, sck_q;
  logic [1:0] sdi_q, sdo_q;
  logic [CW-1:0] cnt;
  logic [FB-1:0] sr;
  logic [AW:0] hdr;
  logic [NREG-1:0][DW-1:0] regs;
  logic oe, od;
  logic [DW-1:0] rdata;
  logic [2:0] bsel;

  wire ser      = ~strap_i;
  wire csn_lo   = ~csn_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire csn_rise = csn_q[1] & ~csn_q[2];
  wire wr_en    = ser & csn_rise & (cnt == CW'(FB)) & ~hdr[AW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csn_q <= 3'b111;
      sck_q <= '0;
      sdi_q <= '0;
      sdo_q <= '0;
    end else begin
      csn_q <= {csn_q[1:0], csn_i};
      sck_q <= {sck_q[1:0], sck_i};
      sdi_q <= {sdi_q[0], sdi_i};
      sdo_q <= {sdo_q[0], sdo_pin_i};
    end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREG; k++)
      if (hdr[AW-1:0] == AW'(k)) rdata = regs[k];
  end

  assign bsel = 3'(CW'(FB - 1) - cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      sr   <= '0;
      hdr  <= '0;
      oe   <= 1'b0;
      od   <= 1'b1;
      regs <= '0;
    end else begin
      if (!ser || !csn_lo) begin
        cnt <= '0;
        oe  <= 1'b0;
      end else begin
        if (sck_rise) begin
          sr <= {sr[FB-2:0], sdi_q[1]};
          if (cnt != CW'(FB + 1)) cnt <= cnt + 1'b1;
          if (cnt == CW'(AW)) hdr <= {sr[AW-1:0], sdi_q[1]};
        end
        if (sck_fall) begin
          oe <= hdr[AW] && (cnt > CW'(AW)) && (cnt < CW'(FB));
          od <= rdata[bsel];
        end
      end
      for (int k = 0; k < NREG; k++)
        if (wr_en && hdr[AW-1:0] == AW'(k)) regs[k] <= sr[DW-1:0];
    end

  assign sdo_pull_o = ser & oe & ~od;
  assign cfg_regs_o = regs;

  logic [1:0] ser_lane, par_lane;
  assign ser_lane = (regs[1][1:0] == 2'd0) ? 2'd0 : (regs[1][1:0] == 2'd1) ? 2'd1 : 2'd2;
  assign par_lane = csn_q[1] ? 2'd2 : (sck_q[1] ? 2'd1 : 2'd0);

  assign lane_code_o  = ser ? ser_lane : par_lane;
  assign power_down_o = ser ? regs[0][0] : sdi_q[1];
  assign low_drive_o  = ser ? regs[1][2] : sdo_q[1];

  p_csn_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csn_q[1] |=> !sdo_pull_o);

  p_pull_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_pull_o |-> (hdr[AW] && cnt > CW'(AW)));

  p_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_rise && hdr[AW]) |=> $stable(cfg_regs_o));

  p_bad_len_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_rise && cnt != CW'(FB)) |=> $stable(cfg_regs_o));

  p_par_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_i) |-> ($stable(cfg_regs_o) && !sdo_pull_o));

  p_lane_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lane_code_o != 2'd3);
endmodule

// File: tb/cnv_mode_port_tb.sv
module cnv_mode_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0, csn = 1'b1, sck = 1'b0, sdi = 1'b0, sdo_pin = 1'b0;
  logic sdo_pull;
  logic [39:0] cfg;
  logic [1:0] lane;
  logic pd, lowd;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cnv_mode_port dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .csn_i(csn), .sck_i(sck),
    .sdi_i(sdi), .sdo_pin_i(sdo_pin), .sdo_pull_o(sdo_pull),
    .cfg_regs_o(cfg), .lane_code_o(lane), .power_down_o(pd), .low_drive_o(lowd)
  );

  localparam logic [15:0] WR_TAB [0:5] = '{16'h00A5, 16'h0106, 16'h023C, 16'h0381, 16'h04FF, 16'h0977};
  localparam logic [6:0]  RD_ADR [0:5] = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd4, 7'd9};
  localparam logic [7:0]  RD_EXP [0:5] = '{8'hA5, 8'h06, 8'h3C, 8'h81, 8'hFF, 8'h00};

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nb, output logic [7:0] rd, output int early);
    rd = '0; early = 0;
    csn = 1'b0; wclk(6);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      wclk(6);
      if (i >= 8 && i < 16) rd[15-i] = ~sdo_pull;
      else if (sdo_pull) early++;
      sck = 1'b1; wclk(6);
      sck = 1'b0;
    end
    wclk(6);
    csn = 1'b1; sdi = 1'b0;
    wclk(10);
  endtask

  initial begin
    logic [7:0] rd;
    int early;
    wclk(3); rst_n = 1'b1; wclk(4);
    check(cfg == 40'h0 && !sdo_pull, "R11 reset state", {sdo_pull, cfg[38:0]}, 40'h0);

    for (int i = 0; i < 6; i++) xfer(WR_TAB[i], 16, rd, early);
    check(cfg == 40'hFF813C06A5, "R2 R7 register file after writes", cfg, 40'hFF813C06A5);
    check(pd == 1'b1 && lowd == 1'b1 && lane == 2'd2, "R10 serial mode outputs",
          {35'h0, pd, lowd, lane}, {35'h0, 1'b1, 1'b1, 2'd2});

    for (int i = 0; i < 6; i++) begin
      xfer({1'b1, RD_ADR[i], 8'h00}, 16, rd, early);
      check(rd == RD_EXP[i], "R3 R7 readback msb first", {32'h0, rd}, {32'h0, RD_EXP[i]});
      check(early == 0, "R4 released in first byte", 40'(early), 40'h0);
    end
    check(!sdo_pull, "R4 released after frame", {39'h0, sdo_pull}, 40'h0);

    xfer(16'h8255, 16, rd, early);
    check(cfg[23:16] == 8'h3C && rd == 8'h3C, "R5 read keeps register", {cfg[23:16], rd}, {8'h3C, 8'h3C});

    xfer(16'h0211, 10, rd, early);
    check(cfg[23:16] == 8'h3C, "R6 short frame dropped", {32'h0, cfg[23:16]}, 40'h3C);
    xfer(16'h0222, 20, rd, early);
    check(cfg[23:16] == 8'h3C, "R6 long frame dropped", {32'h0, cfg[23:16]}, 40'h3C);

    xfer(16'h0101, 16, rd, early);
    check(lane == 2'd1 && lowd == 1'b0, "R10 lane one from register",
          {37'h0, lowd, lane}, {37'h0, 1'b0, 2'd1});
    xfer(16'h0103, 16, rd, early);
    check(lane == 2'd2, "R10 code 3 maps to four lanes", {38'h0, lane}, 40'h2);

    strap = 1'b1; wclk(4);
    for (int p = 0; p < 16; p++) begin
      logic [1:0] el;
      csn = p[3]; sck = p[2]; sdi = p[1]; sdo_pin = p[0];
      wclk(4);
      el = p[3] ? 2'd2 : (p[2] ? 2'd1 : 2'd0);
      check(lane == el, "R1 R8 parallel lane decode", {38'h0, lane}, {38'h0, el});
      check(pd == p[1] && lowd == p[0], "R9 parallel power and drive",
            {38'h0, pd, lowd}, {38'h0, p[1], p[0]});
    end
    csn = 1'b1; sck = 1'b0; sdi = 1'b0; sdo_pin = 1'b0; wclk(4);
    xfer(16'h0055, 16, rd, early);
    xfer(16'h8000, 16, rd, early);
    check(cfg == 40'hFF813C03A5, "R9 serial pins inert in parallel", cfg, 40'hFF813C03A5);
    check(rd == 8'hFF && early == 0, "R9 no SDO pull in parallel", {24'h0, rd, 8'(early)}, {24'h0, 8'hFF, 8'h0});

    strap = 1'b0; wclk(4);
    rst_n = 1'b0; wclk(2); rst_n = 1'b1; wclk(4);
    check(cfg == 40'h0 && !sdo_pull && lane == 2'd0, "R11 reset clears registers", cfg, 40'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule